// File: doc/BRIEF.md
# Channel DC Offset Calibration Engine

This block sits in the digital datapath of a metering front end that serves two measurement channels, voltage and current. Each conversion arrives as a single-cycle strobe carrying a signed 24-bit sample and a channel tag. The block adds that channel's stored DC offset to the sample, scales the sum by that channel's gain, and returns the corrected sample one clock later. The output saturates at the edges of the 24-bit range.

A start command runs an offset calibration on one channel. The first 30 conversions of that channel are discarded to let the input settle. The next N conversions are summed, with N taken from a programmable cycle-count register. On the conversion that completes the count, the negated mean of those samples is written into the channel's offset register. The same edge sets a data-ready status flag, which can drive an interrupt through a mask bit.

Software reaches the offsets, gains, cycle count, status and mask through a simple register port. Writes are synchronous and reads are combinational.

Top module: `dc_offset_cal`

## Requirements
- R1: After reset, both offsets read 0, both gains read 0x400000 (1.0 with 22 fraction bits), the cycle count reads 16, status reads 0, mask reads 0 and `irq` is low. Register addresses are as follows: 0 holds the voltage offset, 1 the voltage gain, 2 the current offset, 3 the current gain, 4 the cycle count N, 5 status (bit 0 is data-ready, bit 1 is busy) and 6 mask (bit 0). Written values read back.
- R2: A strobe on `smp_vld` with tag `smp_ch` (0 = voltage, 1 = current) produces `corr_vld` on the next cycle. That cycle carries the same tag and corr = floor((sample + offset) × gain / 2^22).
- R3: A corrected value above 0x7FFFFF or below −0x800000 is clamped to that limit instead of wrapping.
- R4: Each channel is corrected with its own offset and gain. Calibrating one channel leaves the other channel's offset and gain unchanged.
- R5: After a start, busy reads 1. The offset register and data-ready stay unchanged through the first 30+N−1 conversions of the calibrated channel. Both update on the conversion numbered 30+N, and busy then clears.
- R6: The value written is −(sum / N), with the division truncated toward zero. A result of +0x800000 saturates to 0x7FFFFF.
- R7: Calibration accumulates the raw input samples, as if gain were 1.0 and the offset were 0, whatever the offset and gain registers hold.
- R8: During a calibration, conversions tagged with the other channel are not counted or accumulated.
- R9: A start issued while a calibration is busy is ignored. The running calibration keeps its channel and its count.
- R10: Writing status with bit 0 set clears data-ready. Writing it with bit 0 clear leaves data-ready set.
- R11: `irq` equals data-ready AND mask bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Conversion strobe |
| smp_ch | input | 1 | Channel tag of the sample (0 voltage, 1 current) |
| smp_data | input | 24 | Signed instantaneous sample |
| cal_start | input | 1 | Start an offset calibration |
| cal_ch | input | 1 | Channel to calibrate |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational) |
| corr_vld | output | 1 | Corrected sample valid |
| corr_ch | output | 1 | Channel tag of the corrected sample |
| corr_data | output | 24 | Corrected, saturated sample |
| irq | output | 1 | Masked data-ready interrupt |

## Verification
The bench probes the count boundary. It checks that the offset and data-ready are unchanged after conversion 30+N−1 and set after 30+N. A design with an off-by-one in the settle or accumulate counter writes early, or one conversion late.

A calibration is run with a non-unity gain and a non-zero offset loaded, and with samples from the other channel interleaved. A design that averages corrected samples, or counts foreign conversions, produces the wrong offset.

Negative and positive sums whose mean is not an integer expose rounding toward minus infinity. A full-scale negative mean exposes a negation that wraps instead of saturating.

A second start during a run, and a status write with bit 0 clear, both show whether the design lets those actions disturb its state.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_ACCUM  = 2'd2
    } cal_phase_e;

    localparam logic [2:0] ADDR_OFF_V  = 3'd0;
    localparam logic [2:0] ADDR_GAIN_V = 3'd1;
    localparam logic [2:0] ADDR_OFF_I  = 3'd2;
    localparam logic [2:0] ADDR_GAIN_I = 3'd3;
    localparam logic [2:0] ADDR_CYC    = 3'd4;
    localparam logic [2:0] ADDR_STAT   = 3'd5;
    localparam logic [2:0] ADDR_MASK   = 3'd6;

endpackage

// File: rtl/dcc_corrector.sv
module dcc_corrector #(
    parameter int DW = 24,
    parameter int GF = 22
) (
    input  logic [DW-1:0] smp_i,
    input  logic [DW-1:0] off_i,
    input  logic [DW-1:0] gain_i,
    output logic [DW-1:0] corr_o
);
    localparam int PW = 2 * DW + 2;
    localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] MINV = -PW'(64'sd1 <<< (DW - 1));

    logic signed [DW:0]   sum_s;
    logic signed [DW:0]   gain_s;
    logic signed [PW-1:0] prod_s;
    logic signed [PW-1:0] shift_s;

    always_comb begin
        sum_s   = $signed({smp_i[DW-1], smp_i}) + $signed({off_i[DW-1], off_i});
        gain_s  = $signed({1'b0, gain_i});
        prod_s  = PW'(sum_s) * PW'(gain_s);
        shift_s = prod_s >>> GF;
        if (shift_s > MAXV) begin
            corr_o = MAXV[DW-1:0];
        end else if (shift_s < MINV) begin
            corr_o = MINV[DW-1:0];
        end else begin
            corr_o = shift_s[DW-1:0];
        end
    end
endmodule

// File: rtl/dcc_cal_engine.sv
module dcc_cal_engine
    import dcc_pkg::*;
#(
    parameter int DW     = 24,
    parameter int AW     = 48,
    parameter int NW     = 16,
    parameter int SETTLE = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          start_ch_i,
    input  logic          smp_vld_i,
    input  logic          smp_ch_i,
    input  logic [DW-1:0] smp_i,
    input  logic [NW-1:0] cyc_n_i,
    output logic          busy_o,
    output logic          ch_o,
    output logic          done_o,
    output logic [DW-1:0] off_o
);
    localparam int SW = $clog2(SETTLE + 1);
    localparam int CW = (NW > SW) ? NW : SW;
    localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [AW-1:0] MINV = -AW'(64'sd1 <<< (DW - 1));

    typedef struct packed {
        cal_phase_e           phase;
        logic                 ch;
        logic [CW-1:0]        cnt;
        logic [NW-1:0]        n;
        logic signed [AW-1:0] acc;
    } eng_t;

    eng_t eng_d, eng_q;

    logic                 hit;
    logic signed [AW-1:0] acc_nxt;
    logic signed [AW-1:0] div_s;
    logic signed [AW-1:0] mean_s;
    logic signed [AW-1:0] neg_s;

    always_comb begin
        eng_d   = eng_q;
        done_o  = 1'b0;
        hit     = smp_vld_i && (smp_ch_i == eng_q.ch);
        acc_nxt = eng_q.acc + $signed({{(AW-DW){smp_i[DW-1]}}, smp_i});
        div_s   = $signed({{(AW-NW){1'b0}}, eng_q.n});
        mean_s  = acc_nxt / div_s;
        neg_s   = -mean_s;
        if (neg_s > MAXV) begin
            off_o = MAXV[DW-1:0];
        end else if (neg_s < MINV) begin
            off_o = MINV[DW-1:0];
        end else begin
            off_o = neg_s[DW-1:0];
        end

        case (eng_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    eng_d.phase = PH_SETTLE;
                    eng_d.ch    = start_ch_i;
                    eng_d.cnt   = '0;
                    eng_d.acc   = '0;
                    eng_d.n     = (cyc_n_i == '0) ? NW'(1) : cyc_n_i;
                end
            end
            PH_SETTLE: begin
                if (hit) begin
                    if (eng_q.cnt == CW'(SETTLE - 1)) begin
                        eng_d.phase = PH_ACCUM;
                        eng_d.cnt   = '0;
                    end else begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end
                end
            end
            PH_ACCUM: begin
                if (hit) begin
                    eng_d.acc = acc_nxt;
                    if (eng_q.cnt == CW'(eng_q.n - 1'b1)) begin
                        eng_d.phase = PH_IDLE;
                        done_o      = 1'b1;
                    end else begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end
                end
            end
            default: eng_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{phase: PH_IDLE, ch: 1'b0, cnt: '0, n: NW'(1), acc: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy_o = (eng_q.phase != PH_IDLE);
    assign ch_o   = eng_q.ch;
endmodule

// File: rtl/dc_offset_cal.sv
module dc_offset_cal
    import dcc_pkg::*;
#(
    parameter int DW     = 24,
    parameter int AW     = 48,
    parameter int NW     = 16,
    parameter int GF     = 22,
    parameter int SETTLE = 30,
    parameter int N_RST  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic          smp_ch,
    input  logic [DW-1:0] smp_data,
    input  logic          cal_start,
    input  logic          cal_ch,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          corr_vld,
    output logic          corr_ch,
    output logic [DW-1:0] corr_data,
    output logic          irq
);
    localparam logic [DW-1:0] GAIN_ONE = DW'(1) << GF;
    localparam int NCH = 2;

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] off;
        logic [NCH-1:0][DW-1:0] gain;
        logic [NW-1:0]          cyc;
        logic                   drdy;
        logic                   mask;
        logic                   cvld;
        logic                   cch;
        logic [DW-1:0]          cdata;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NCH-1:0][DW-1:0] corr_w;
    logic                   eng_busy;
    logic                   eng_ch;
    logic                   eng_done;
    logic [DW-1:0]          eng_off;

    for (genvar c = 0; c < NCH; c++) begin : g_corr
        dcc_corrector #(.DW(DW), .GF(GF)) u_corr (
            .smp_i  (smp_data),
            .off_i  (regs_q.off[c]),
            .gain_i (regs_q.gain[c]),
            .corr_o (corr_w[c])
        );
    end

    dcc_cal_engine #(.DW(DW), .AW(AW), .NW(NW), .SETTLE(SETTLE)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (cal_start),
        .start_ch_i (cal_ch),
        .smp_vld_i  (smp_vld),
        .smp_ch_i   (smp_ch),
        .smp_i      (smp_data),
        .cyc_n_i    (regs_q.cyc),
        .busy_o     (eng_busy),
        .ch_o       (eng_ch),
        .done_o     (eng_done),
        .off_o      (eng_off)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.cvld = smp_vld;
        if (smp_vld) begin
            regs_d.cch   = smp_ch;
            regs_d.cdata = corr_w[smp_ch];
        end
        if (reg_we) begin
            case (reg_addr)
                ADDR_OFF_V:  regs_d.off[0]  = reg_wdata;
                ADDR_GAIN_V: regs_d.gain[0] = reg_wdata;
                ADDR_OFF_I:  regs_d.off[1]  = reg_wdata;
                ADDR_GAIN_I: regs_d.gain[1] = reg_wdata;
                ADDR_CYC:    regs_d.cyc     = reg_wdata[NW-1:0];
                ADDR_STAT:   if (reg_wdata[0]) regs_d.drdy = 1'b0;
                ADDR_MASK:   regs_d.mask    = reg_wdata[0];
                default: ;
            endcase
        end
        if (eng_done) begin
            regs_d.off[eng_ch] = eng_off;
            regs_d.drdy        = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{off: '0, gain: {NCH{GAIN_ONE}}, cyc: NW'(N_RST),
                        drdy: 1'b0, mask: 1'b0, cvld: 1'b0, cch: 1'b0, cdata: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_OFF_V:  reg_rdata = regs_q.off[0];
            ADDR_GAIN_V: reg_rdata = regs_q.gain[0];
            ADDR_OFF_I:  reg_rdata = regs_q.off[1];
            ADDR_GAIN_I: reg_rdata = regs_q.gain[1];
            ADDR_CYC:    reg_rdata = DW'(regs_q.cyc);
            ADDR_STAT:   reg_rdata = DW'({eng_busy, regs_q.drdy});
            ADDR_MASK:   reg_rdata = DW'(regs_q.mask);
            default:     reg_rdata = '0;
        endcase
    end

    assign corr_vld  = regs_q.cvld;
    assign corr_ch   = regs_q.cch;
    assign corr_data = regs_q.cdata;
    assign irq       = regs_q.drdy & regs_q.mask;

    logic          drdy_s;
    logic          mask_s;
    logic [DW-1:0] off_v_s;
    assign drdy_s  = regs_q.drdy;
    assign mask_s  = regs_q.mask;
    assign off_v_s = regs_q.off[0];
endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld,
    input logic          corr_vld,
    input logic          cal_start,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic          irq,
    input logic          drdy,
    input logic          mask,
    input logic          busy,
    input logic          done,
    input logic          eng_ch,
    input logic [DW-1:0] off_v
);
    // R2
    corr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> corr_vld);

    // R2
    corr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !corr_vld);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask |-> !irq);

    // R5
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> drdy);

    // R9
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cal_start && !done) |=> (busy && $stable(eng_ch)));

    // R4
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !(reg_we && reg_addr == 3'd0)) |=> $stable(off_v));
endmodule

bind dc_offset_cal dcc_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .corr_vld  (corr_vld),
    .cal_start (cal_start),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .irq       (irq),
    .drdy      (drdy_s),
    .mask      (mask_s),
    .busy      (eng_busy),
    .done      (eng_done),
    .eng_ch    (eng_ch),
    .off_v     (off_v_s)
);

// File: tb/test_dc_offset_cal.sv
module test_dc_offset_cal;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic        smp_ch = 1'b0;
    logic [23:0] smp_data = '0;
    logic        cal_start = 1'b0;
    logic        cal_ch = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        corr_vld;
    logic        corr_ch;
    logic [23:0] corr_data;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit ended = 0;
    int off_m [2];
    int gain_m [2];
    logic [24:0] exp_q [$];

    always #5 clk = ~clk;

    dc_offset_cal i_dc_offset_cal (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_ch(smp_ch),
        .smp_data(smp_data), .cal_start(cal_start), .cal_ch(cal_ch),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .corr_vld(corr_vld), .corr_ch(corr_ch),
        .corr_data(corr_data), .irq(irq)
    );

    function automatic logic [23:0] exp_corr(int x, int off, int g);
        longint p;
        p = (longint'(x) + longint'(off)) * longint'(g);
        p = p >>> 22;
        if (p > 64'sd8388607) return 24'h7FFFFF;
        if (p < -64'sd8388608) return 24'h800000;
        return p[23:0];
    endfunction

    task automatic check(bit ok, string tag, logic [23:0] act, logic [23:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [23:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(logic [2:0] a, logic [23:0] expv, string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata === expv, tag, reg_rdata, expv);
    endtask

    task automatic send(bit ch, int x);
        @(negedge clk);
        smp_vld = 1'b1; smp_ch = ch; smp_data = x[23:0];
        exp_q.push_back({ch, exp_corr(x, off_m[ch], gain_m[ch])});
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic start_cal(bit ch);
        @(negedge clk);
        cal_start = 1'b1; cal_ch = ch;
        @(negedge clk);
        cal_start = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && corr_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected output", corr_data, 24'h0);
            end else begin
                logic [24:0] e;
                e = exp_q.pop_front();
                check({corr_ch, corr_data} === e, "R2/R3/R4 corrected sample", corr_data, e[23:0]);
                check(corr_ch === e[24], "R2 channel tag", {23'h0, corr_ch}, {23'h0, e[24]});
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        off_m[0] = 0; off_m[1] = 0; gain_m[0] = 32'h400000; gain_m[1] = 32'h400000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(3'd0, 24'h0, "R1 off_v reset");
        rd_chk(3'd1, 24'h400000, "R1 gain_v reset");
        rd_chk(3'd3, 24'h400000, "R1 gain_i reset");
        rd_chk(3'd4, 24'd16, "R1 cyc reset");
        rd_chk(3'd5, 24'h0, "R1 status reset");
        rd_chk(3'd6, 24'h0, "R1 mask reset");
        check(irq === 1'b0, "R1 irq reset", {23'h0, irq}, 24'h0);

        // R1 write/readback, model update
        wr(3'd0, 24'd100);       off_m[0] = 100;
        wr(3'd1, 24'h200000);    gain_m[0] = 32'h200000;
        wr(3'd2, -24'sd50);      off_m[1] = -50;
        wr(3'd3, 24'h600000);    gain_m[1] = 32'h600000;
        rd_chk(3'd0, 24'd100, "R1 off_v readback");
        rd_chk(3'd3, 24'h600000, "R1 gain_i readback");

        // R2 / R4 correction on both channels
        send(1'b0, 1000);
        send(1'b0, -3000);
        send(1'b1, 1000);
        send(1'b1, -7);

        // R3 saturation both ways
        wr(3'd3, 24'hFFFFFF);    gain_m[1] = 32'hFFFFFF;
        send(1'b1, 32'sh7FFFFF);
        send(1'b1, -32'sh800000);
        wr(3'd3, 24'h600000);    gain_m[1] = 32'h600000;

        // R5 R7 R8 R9: calibrate voltage with N=4, non-unity gain loaded
        wr(3'd4, 24'd4);
        start_cal(1'b0);
        rd_chk(3'd5, 24'h2, "R5 busy after start");
        for (int k = 0; k < 30; k++) begin
            send(1'b0, 5000);
            if (k % 10 == 0) send(1'b1, 123456);   // R8 foreign samples
        end
        start_cal(1'b1);                            // R9 ignored
        send(1'b0, 10);
        send(1'b1, -400000);                        // R8
        send(1'b0, 11);
        send(1'b0, 12);
        rd_chk(3'd0, 24'd100, "R5 offset unchanged before last conversion");
        rd_chk(3'd5, 24'h2, "R5 busy, no data-ready before last conversion");
        send(1'b0, -3);
        off_m[0] = -7;
        rd_chk(3'd0, -24'sd7, "R6 R7 offset = -(30/4 trunc)");
        rd_chk(3'd5, 24'h1, "R5 data-ready set, busy clear");
        rd_chk(3'd2, -24'sd50, "R4 R9 other channel offset untouched");
        check(irq === 1'b0, "R11 irq masked", {23'h0, irq}, 24'h0);
        send(1'b0, 200);

        // R11 / R10
        wr(3'd6, 24'h1);
        #1 check(irq === 1'b1, "R11 irq with mask", {23'h0, irq}, 24'h1);
        wr(3'd5, 24'h0);
        rd_chk(3'd5, 24'h1, "R10 write 0 keeps data-ready");
        wr(3'd5, 24'h1);
        rd_chk(3'd5, 24'h0, "R10 write 1 clears data-ready");
        check(irq === 1'b0, "R11 irq low after clear", {23'h0, irq}, 24'h0);

        // R6 negative sum on current channel, truncate toward zero
        start_cal(1'b1);
        for (int k = 0; k < 30; k++) send(1'b1, 0);
        send(1'b1, -10);
        send(1'b1, -11);
        send(1'b1, -12);
        send(1'b1, 3);
        off_m[1] = 7;
        rd_chk(3'd2, 24'd7, "R6 offset = -(-30/4 trunc)");
        rd_chk(3'd0, -24'sd7, "R4 voltage offset untouched");
        rd_chk(3'd1, 24'h200000, "R4 voltage gain untouched");
        check(irq === 1'b1, "R11 irq after second run", {23'h0, irq}, 24'h1);
        send(1'b1, 50);

        // R6 saturation of negated full-scale mean, N=1
        wr(3'd4, 24'd1);
        start_cal(1'b0);
        for (int k = 0; k < 30; k++) send(1'b0, 1);
        send(1'b0, -32'sh800000);
        off_m[0] = 32'sh7FFFFF;
        rd_chk(3'd0, 24'h7FFFFF, "R6 saturated offset");
        send(1'b0, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all outputs produced", 24'(exp_q.size()), 24'h0);
        finish_run();
    end
endmodule